// File: doc/BRIEF.md
# Asynchronous Memory Bus Controller

This block sits between a simple processor request port and an external static memory that ends each access by raising a ready line. The processor side offers one request at a time over a valid/ready handshake: an address, a read or write command, write data, and a byte-or-word size flag. The controller then runs the access on the memory side. It drives a one-way address bus and a shared data bus with an explicit drive enable. It also drives separate read and write strobes and a size line. It holds the strobe until the memory answers, so the memory sets the number of wait states.

For writes, the controller drives the address, data and size for a programmable number of clock cycles before the write strobe goes active, which gives the memory a setup window. The memory's ready line passes through a two-stage synchronizer before the state machine uses it. A watchdog counter ends an access that never receives ready, releases the bus and reports an error with the completion pulse. The strobes and the data bus are always released for one cycle before the next request can be taken.

Top module: `amb_ctrl`

## Requirements
- R1: `mem_addr` is always an output. During a read, `mem_data_oe` is low and the controller does not drive `mem_data`, so the memory can drive it.
- R2: A read asserts `mem_rd` while `mem_addr` and `mem_size` already carry the request's address and size. When the synchronized ready is seen, the value on `mem_data` is captured and returned on `rsp_rdata`.
- R3: A write drives `mem_addr`, `mem_data` (with `mem_data_oe` high) and `mem_size` for exactly `SETUP_CYC` clock cycles with `mem_wr` low, then raises `mem_wr`.
- R4: `mem_size` follows the request flag `req_size` (0 = byte, 1 = word). A byte read returns bits 7:0 of the bus with all higher bits of `rsp_rdata` zero. A word read returns the whole bus.
- R5: `mem_ready` is synchronized through two flops. The active strobe falls at the second rising edge after the first edge at which `mem_ready` is sampled high. When ready rises L cycles after the strobe, the strobe is high for L+3 cycles.
- R6: If ready never arrives, the strobe is released after `TIMEOUT_CYC` cycles high, and the completion carries `rsp_err` = 1. An access that receives ready completes with `rsp_err` = 0.
- R7: `rsp_done` is a one-cycle pulse in the cycle right after the strobe falls. In that cycle `mem_rd`, `mem_wr` and `mem_data_oe` are all low.
- R8: `req_ready` is high only when the controller is idle and the synchronized ready is low. A request is taken at a rising edge where both `req_valid` and `req_ready` are high, and `req_ready` stays low until the completion has passed.
- R9: After reset, `mem_rd`, `mem_wr`, `mem_data_oe` and `rsp_done` are low and `req_ready` is high.
- R10: While `mem_wr` is high, `mem_addr` and the driven `mem_data` hold the request's values without change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 1 | 0 = byte, 1 = word |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion ended by timeout |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| mem_addr | output | ADDR_W | Memory address bus |
| mem_data | inout | DATA_W | Shared memory data bus |
| mem_data_oe | output | 1 | Controller drives mem_data |
| mem_rd | output | 1 | Read strobe, active high |
| mem_wr | output | 1 | Write strobe, active high |
| mem_size | output | 1 | Access size to memory |
| mem_ready | input | 1 | Asynchronous ready from memory |

## Verification
The bench sweeps every address of a small memory model at several response latencies. It runs word and byte writes and reads back each location, so a controller that ignored the size flag would corrupt the upper byte, and one that failed to zero-extend a byte read would return stale high bits. For each access it counts the cycles of setup and of strobe against the expected counts. A synchronizer with the wrong depth, or a missing setup window, shows up there as an off-by-one count. Accesses that never get ready check that the timeout fires at the parameterized count and flags an error. Each following access checks that the error flag clears and that the completion pulse lasts exactly one cycle with the bus released.

// File: rtl/amb_pkg.sv
package amb_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2,
        ST_DONE   = 2'd3
    } amb_state_e;

    typedef enum logic {
        SZ_BYTE = 1'b0,
        SZ_WORD = 1'b1
    } amb_size_e;

    typedef struct packed {
        logic      write;
        amb_size_e size;
    } amb_kind_t;

    function automatic int amb_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/amb_sync.sv
module amb_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) chain <= '0;
        else     chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/amb_cnt.sv
module amb_cnt #(
    parameter int MAXV = 255,
    parameter int W    = $clog2(MAXV + 1)
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst || clr)           q <= '0;
        else if (q != W'(MAXV))   q <= q + 1'b1;
    end
endmodule

// File: rtl/amb_rdcap.sv
module amb_rdcap #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cap,
    input  logic              word,
    input  logic [DATA_W-1:0] bus,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] shaped;

    generate
        if (DATA_W > 8) begin : g_wide
            always_comb shaped = word ? bus : {{(DATA_W-8){1'b0}}, bus[7:0]};
        end else begin : g_narrow
            always_comb shaped = bus;
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst)      rdata <= '0;
        else if (cap) rdata <= shaped;
    end
endmodule

// File: rtl/amb_ctrl.sv
module amb_ctrl
    import amb_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 16,
    parameter int SETUP_CYC   = 1,
    parameter int TIMEOUT_CYC = 255
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic              req_size,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              rsp_done,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic [ADDR_W-1:0] mem_addr,
    inout  wire  [DATA_W-1:0] mem_data,
    output logic              mem_data_oe,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              mem_size,
    input  logic              mem_ready
);
    localparam int CNT_MAX = amb_max(SETUP_CYC, TIMEOUT_CYC);
    localparam int CNT_W   = $clog2(CNT_MAX + 1);
    localparam logic [CNT_W-1:0] SETUP_LAST = CNT_W'(amb_max(SETUP_CYC - 1, 0));
    localparam logic [CNT_W-1:0] TMO_LAST   = CNT_W'(TIMEOUT_CYC - 1);

    amb_state_e        state, nstate;
    amb_kind_t         kind;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q;
    logic              err_q;
    logic              rdy_s;
    logic [CNT_W-1:0]  cnt;
    logic              take;
    logic              cap;

    amb_sync #(.STAGES(2)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (mem_ready),
        .q   (rdy_s)
    );

    amb_cnt #(.MAXV(CNT_MAX), .W(CNT_W)) u_cnt (
        .clk (clk),
        .rst (rst),
        .clr (state != nstate),
        .q   (cnt)
    );

    assign req_ready = (state == ST_IDLE) && !rdy_s;
    assign take      = req_valid && req_ready;
    assign cap       = (state == ST_STROBE) && rdy_s && !kind.write;

    always_comb begin
        nstate = state;
        unique case (state)
            ST_IDLE: begin
                if (take) nstate = (req_write && SETUP_CYC > 0) ? ST_SETUP : ST_STROBE;
            end
            ST_SETUP: begin
                if (cnt == SETUP_LAST) nstate = ST_STROBE;
            end
            ST_STROBE: begin
                if (rdy_s || cnt == TMO_LAST) nstate = ST_DONE;
            end
            ST_DONE: nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            kind    <= '{write: 1'b0, size: SZ_BYTE};
            addr_q  <= '0;
            wdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            state <= nstate;
            if (take) begin
                kind    <= '{write: req_write, size: amb_size_e'(req_size)};
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
            end
            if (state == ST_STROBE && nstate == ST_DONE) err_q <= !rdy_s;
        end
    end

    amb_rdcap #(.DATA_W(DATA_W)) u_rdcap (
        .clk   (clk),
        .rst   (rst),
        .cap   (cap),
        .word  (kind.size == SZ_WORD),
        .bus   (mem_data),
        .rdata (rsp_rdata)
    );

    assign mem_addr    = addr_q;
    assign mem_size    = kind.size;
    assign mem_rd      = (state == ST_STROBE) && !kind.write;
    assign mem_wr      = (state == ST_STROBE) &&  kind.write;
    assign mem_data_oe = kind.write && (state == ST_SETUP || state == ST_STROBE);
    assign mem_data    = mem_data_oe ? wdata_q : {DATA_W{1'bz}};
    assign rsp_done    = (state == ST_DONE);
    assign rsp_err     = rsp_done && err_q;
endmodule

// File: rtl/amb_ctrl_chk.sv
module amb_ctrl_chk #(
    parameter int ADDR_W    = 16,
    parameter int DATA_W    = 16,
    parameter int SETUP_CYC = 1
) (
    input logic              clk,
    input logic              rst,
    input logic              req_ready,
    input logic              rsp_done,
    input logic              rsp_err,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [DATA_W-1:0] mem_data,
    input logic              mem_data_oe,
    input logic              mem_rd,
    input logic              mem_wr
);
    AST_READ_NO_DRIVE: assert property (@(posedge clk) disable iff (rst)
        mem_rd |-> !mem_data_oe);                                            // R1
    AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd && mem_wr));                                                // R2
    AST_WR_AFTER_SETUP: assert property (@(posedge clk) disable iff (rst)
        ($rose(mem_wr) && SETUP_CYC > 0) |-> $past(mem_data_oe));            // R3
    AST_ERR_WITH_DONE: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_done);                                               // R6
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);                                             // R7
    AST_DONE_RELEASED: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> (!mem_rd && !mem_wr && !mem_data_oe));                  // R7
    AST_READY_IDLE: assert property (@(posedge clk) disable iff (rst)
        req_ready |-> (!mem_rd && !mem_wr && !rsp_done));                    // R8
    AST_WR_STABLE: assert property (@(posedge clk) disable iff (rst)
        (mem_wr && $past(mem_wr)) |-> ($stable(mem_addr) && $stable(mem_data))); // R10
endmodule

bind amb_ctrl amb_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SETUP_CYC(SETUP_CYC)
) u_amb_ctrl_chk (
    .clk(clk), .rst(rst), .req_ready(req_ready), .rsp_done(rsp_done),
    .rsp_err(rsp_err), .mem_addr(mem_addr), .mem_data(mem_data),
    .mem_data_oe(mem_data_oe), .mem_rd(mem_rd), .mem_wr(mem_wr)
);

// File: tb/amb_ctrl_bench.sv
module amb_ctrl_bench;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int SETUP = 2;
    localparam int TMO = 20;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0, req_write = 1'b0, req_size = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, rsp_done, rsp_err;
    logic [DW-1:0] rsp_rdata;
    logic [AW-1:0] mem_addr;
    wire  [DW-1:0] mem_data;
    logic          mem_data_oe, mem_rd, mem_wr, mem_size, mem_ready;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    // memory model
    logic [DW-1:0] store [16];
    logic [DW-1:0] expv  [16];
    int            lat = 0;
    logic          hang = 1'b0;
    int            scnt = 0;

    always #10 clk = ~clk;

    amb_ctrl #(.ADDR_W(AW), .DATA_W(DW), .SETUP_CYC(SETUP), .TIMEOUT_CYC(TMO)) u_amb_ctrl (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_size(req_size), .req_addr(req_addr),
        .req_wdata(req_wdata), .rsp_done(rsp_done), .rsp_err(rsp_err),
        .rsp_rdata(rsp_rdata), .mem_addr(mem_addr), .mem_data(mem_data),
        .mem_data_oe(mem_data_oe), .mem_rd(mem_rd), .mem_wr(mem_wr),
        .mem_size(mem_size), .mem_ready(mem_ready)
    );

    assign mem_ready = (mem_rd || mem_wr) && !hang && (scnt >= lat);
    assign mem_data  = (mem_rd && !mem_data_oe) ? store[mem_addr] : {DW{1'bz}};

    always_ff @(posedge clk) begin
        if (mem_rd || mem_wr) scnt <= scnt + 1;
        else                  scnt <= 0;
        if (mem_wr && mem_ready) begin
            if (mem_size) store[mem_addr] <= mem_data;
            else          store[mem_addr][7:0] <= mem_data[7:0];
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // one access; returns observed counts and flags
    task automatic xfer(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic sz, input int l, input logic hg,
                        output logic [DW-1:0] rd, output logic er,
                        output int stb, output int stp, output bit bad, output bit pulse_ok);
        lat = l; hang = hg; stb = 0; stp = 0; bad = 0; pulse_ok = 1; rd = '0; er = 1'b0;
        @(negedge clk);
        for (int g = 0; g < 100 && !req_ready; g++) @(negedge clk);
        req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_size = sz;
        @(negedge clk);
        req_valid = 1'b0;
        for (int k = 0; k < 500; k++) begin
            if (rsp_done) begin
                rd = rsp_rdata; er = rsp_err;
                if (mem_rd || mem_wr || mem_data_oe) pulse_ok = 0;
                break;
            end
            if (req_ready) bad = 1;
            if (mem_rd || mem_wr) begin
                stb++;
                if (mem_addr !== a || mem_size !== sz) bad = 1;
            end
            if (mem_data_oe && !mem_wr && stb == 0) stp++;
            if (mem_rd && mem_data_oe) bad = 1;
            if (mem_data_oe && mem_data !== d) bad = 1;
            @(negedge clk);
        end
        @(negedge clk);
        if (rsp_done) pulse_ok = 0;
    endtask

    task automatic run_one(input logic w, input logic [AW-1:0] a, input logic [DW-1:0] d,
                           input logic sz, input int l);
        logic [DW-1:0] rd; logic er; int stb, stp; bit bad, pok;
        logic [DW-1:0] exp_rd;
        xfer(w, a, d, sz, l, 1'b0, rd, er, stb, stp, bad, pok);
        chk(stb == l + 3, "R5 strobe length", stb, l + 3);
        chk(!er, "R6 no error when ready arrives", er, 0);
        chk(pok, "R7 single done pulse with bus released", pok, 1);
        chk(!bad, "R1/R8/R10 bus and handshake during access", bad, 0);
        if (w) begin
            chk(stp == SETUP, "R3 write setup cycles", stp, SETUP);
            if (sz) expv[a] = d;
            else    expv[a][7:0] = d[7:0];
        end else begin
            chk(stp == 0, "R1 read never drives bus", stp, 0);
            exp_rd = sz ? expv[a] : {8'h00, expv[a][7:0]};
            chk(rd == exp_rd, sz ? "R2 word read data" : "R4 byte read zero-extended", rd, exp_rd);
        end
    endtask

    initial begin
        logic [DW-1:0] rd; logic er; int stb, stp; bit bad, pok;
        for (int i = 0; i < 16; i++) begin store[i] = '0; expv[i] = '0; end
        repeat (3) @(negedge clk);
        chk(!mem_rd && !mem_wr && !mem_data_oe && !rsp_done, "R9 outputs idle in reset", {mem_rd, mem_wr, mem_data_oe, rsp_done}, 0);
        rst = 1'b0;
        @(negedge clk);
        chk(req_ready === 1'b1, "R9 ready after reset", req_ready, 1);
        chk(!mem_rd && !mem_wr && !mem_data_oe, "R9 strobes low after reset", {mem_rd, mem_wr, mem_data_oe}, 0);

        for (int l = 0; l < 5; l++) begin
            for (int a = 0; a < 16; a++) begin
                logic [DW-1:0] wv, bv;
                wv = DW'((a * 16'h1357) ^ (l * 16'h2461) ^ 16'hA5C3);
                bv = DW'((a * 16'h0031) + l * 16'h0107 + 16'h5A00);
                run_one(1'b1, AW'(a), wv, 1'b1, l);
                run_one(1'b0, AW'(a), '0, 1'b1, l);
                run_one(1'b1, AW'(a), bv, 1'b0, (l + a) % 5);
                run_one(1'b0, AW'(a), '0, 1'b0, l);
                run_one(1'b0, AW'(a), '0, 1'b1, (l + 2) % 5);
            end
        end

        // R6: timeouts on read and write, then recovery
        xfer(1'b0, 4'd3, '0, 1'b1, 0, 1'b1, rd, er, stb, stp, bad, pok);
        chk(stb == TMO, "R6 read timeout length", stb, TMO);
        chk(er == 1'b1, "R6 read timeout error", er, 1);
        chk(pok, "R7 pulse after timeout", pok, 1);
        xfer(1'b1, 4'd7, 16'hBEEF, 1'b1, 0, 1'b1, rd, er, stb, stp, bad, pok);
        chk(stb == TMO, "R6 write timeout length", stb, TMO);
        chk(er == 1'b1, "R6 write timeout error", er, 1);
        chk(stp == SETUP, "R3 setup before timed-out write", stp, SETUP);
        run_one(1'b0, 4'd7, '0, 1'b1, 1);
        run_one(1'b1, 4'd7, 16'h1234, 1'b1, 6);
        run_one(1'b0, 4'd7, '0, 1'b0, 6);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks++;
            errors++;
            $display("FAIL watchdog: run hung actual=%0d expected<150000", cyc);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule